// File: doc/BRIEF.md
# Windowed Watchdog and Reset Supervisor

This block supervises a processor from two directions. It drives an active-low system reset. That reset is held low from power-up, and again whenever the monitored supply is reported low or the chip is in shutdown. It is released only after a fixed number of clean cycles. It also drives an active-low watchdog output, which checks the rhythm of a software kick signal.

While the watchdog is enabled and the chip is not in shutdown, the block measures the time between falling edges of the kick input. This time must lie inside a window with a lower and an upper bound. An edge that comes too soon, or a silence that lasts past the upper bound, starts a low pulse on the watchdog output. The pulse length equals the reset delay. After each pulse the watchdog re-arms, and it waits for a fresh first edge before it times anything again. All limits are parameters counted in clock cycles. The supply-sense, shutdown and enable inputs are taken as synchronous to the clock. The kick input may be asynchronous.

Top module: `window_watchdog_sup`

## Requirements
- R1: After `rst_n` goes high, `sys_rst_n` stays low for exactly RST_DELAY rising edges and is high from the RST_DELAY-th edge on, provided `sense_ok` is 1 and `shutdown` is 0 throughout.
- R2: `sys_rst_n` is 0 in any cycle in which `sense_ok` is 0 or `shutdown` is 1, with no clock delay.
- R3: When `sense_ok` becomes 1 and `shutdown` becomes 0, `sys_rst_n` rises on the RST_DELAY-th rising edge that samples both inputs clean, and not before.
- R4: While `wd_en` is 0 (one edge after it falls) or `shutdown` is 1, `wd_out_n` is 1 and kick edges have no effect.
- R5: Only falling edges of `kick` count. Each one passes a two-flop synchronizer and is acted on at the third rising edge after the input changes. An interval between counted edges of WIN_MIN to WIN_MAX cycles, both bounds included, keeps `wd_out_n` at 1.
- R6: An interval shorter than WIN_MIN cycles drives `wd_out_n` low in the cycle after the offending edge is acted on.
- R7: If WIN_MAX cycles pass after a counted edge with no further falling edge, `wd_out_n` goes low at once, without waiting for an edge.
- R8: A watchdog low pulse lasts exactly RST_DELAY cycles. If `shutdown` rises during the pulse, `wd_out_n` goes high in that same cycle.
- R9: When the watchdog is enabled, and when a pulse ends, the next falling edge only starts the timing. Until that edge arrives, no fault can occur.
- R10: Falling edges that arrive during a watchdog pulse are ignored. They neither lengthen the pulse nor start timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| sense_ok | input | 1 | 1 when the monitored supply is above its threshold |
| shutdown | input | 1 | 1 while the chip is in shutdown |
| wd_en | input | 1 | Watchdog enable |
| kick | input | 1 | Software kick; falling edges are measured |
| sys_rst_n | output | 1 | Active-low system reset |
| wd_out_n | output | 1 | Active-low watchdog fault pulse |

## Verification
The bench places kick intervals exactly at WIN_MIN and WIN_MAX, and then one cycle under the minimum. A design that compares with an off-by-one bound would fault on a legal interval or miss the early one. It lets the kick go quiet until the upper limit passes, which exposes a late check that waits for an edge. It also kicks inside a fault pulse and then stays silent for longer than WIN_MAX. A design that takes that edge as a timing start would raise a second, late fault. Finally, the bench counts reset release and pulse length to the exact cycle, and raises shutdown in the middle of a pulse. A timer that is one cycle long or short, or a pulse that ignores shutdown, shows up at the output.

// File: rtl/sup_pkg.sv
// Package: shared types and width helpers for the supervisor.
// Assumes all counts are small positive integers.
package sup_pkg;

    // States of the watchdog window judge.
    typedef enum logic [1:0] {
        WD_IDLE   = 2'd0,
        WD_ARMED  = 2'd1,
        WD_TIMING = 2'd2,
        WD_FAULT  = 2'd3
    } wd_state_e;

    // Bits needed to hold values 0..v.
    function automatic int bits_for(input int v);
        return (v < 1) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/kick_edge_sync.sv
// Module: brings an asynchronous kick input into the clock domain
// through STAGES flops, then flags a one-cycle falling edge.
// Assumes the kick idles high; reset loads the chain with ones.
module kick_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_async,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Synchronizer chain, one flop per stage.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= kick_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Previous synchronized value, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/hold_timer.sv
// Module: saturating delay counter. Clear forces the count to zero.
// Otherwise the count climbs to DELAY and stays there.
// LOOKAHEAD=0 flags expiry once the count sits at DELAY.
// LOOKAHEAD=1 flags the last cycle before that, so a registered
// consumer can act at the DELAY-th edge. Assumes DELAY >= 1.
module hold_timer #(
    parameter int DELAY     = 8,
    parameter bit LOOKAHEAD = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expire
);
    localparam int CW = sup_pkg::bits_for(DELAY);
    localparam logic [CW-1:0] LIMIT = CW'(DELAY);
    localparam logic [CW-1:0] LIMIT_M1 = CW'(DELAY - 1);

    logic [CW-1:0] cnt;

    // Count clean cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (clear)         cnt <= '0;
        else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
    end

    // Pick the expiry flavour.
    generate
        if (LOOKAHEAD) begin : g_early
            assign expire = !clear && (cnt == LIMIT_M1);
        end else begin : g_late
            assign expire = (cnt == LIMIT);
        end
    endgenerate
endmodule

// File: rtl/window_judge.sv
// Module: watchdog state machine. It measures the cycles between
// counted falling edges and enters FAULT on an early edge or a
// too-long silence. It leaves FAULT when the pulse timer ends.
// Assumes 1 <= WIN_MIN <= WIN_MAX.
module window_judge #(
    parameter int WIN_MIN = 10,
    parameter int WIN_MAX = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic fall,
    input  logic pulse_end,
    output logic fault_on
);
    import sup_pkg::*;

    localparam int IW = bits_for(WIN_MAX);
    localparam logic [IW-1:0] MIN_V = IW'(WIN_MIN);
    localparam logic [IW-1:0] MAX_V = IW'(WIN_MAX);

    wd_state_e     state;
    logic [IW-1:0] icnt;
    logic [IW-1:0] elapsed;

    assign elapsed = icnt + 1'b1;

    // Window tracking: arm, time, judge, and hold the fault.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state <= WD_IDLE;
            icnt  <= '0;
        end else begin
            unique case (state)
                WD_IDLE: begin
                    state <= WD_ARMED;
                    icnt  <= '0;
                end
                WD_ARMED: begin
                    if (fall) begin
                        state <= WD_TIMING;
                        icnt  <= '0;
                    end
                end
                WD_TIMING: begin
                    if (fall) begin
                        if (elapsed < MIN_V) state <= WD_FAULT;
                        icnt <= '0;
                    end else if (elapsed == MAX_V) begin
                        state <= WD_FAULT;
                        icnt  <= '0;
                    end else begin
                        icnt <= elapsed;
                    end
                end
                WD_FAULT: begin
                    if (pulse_end) begin
                        state <= WD_ARMED;
                        icnt  <= '0;
                    end
                end
                default: state <= WD_IDLE;
            endcase
        end
    end

    assign fault_on = (state == WD_FAULT);
endmodule

// File: rtl/window_watchdog_sup.sv
// Top: reset supervisor plus windowed watchdog. Power-up and supply
// or shutdown faults hold sys_rst_n low, and it releases RST_DELAY
// cycles after all is clean. Watchdog faults pulse wd_out_n low for
// the same delay. Assumes sense_ok, shutdown and wd_en are
// synchronous to clk; kick may be asynchronous.
module window_watchdog_sup #(
    parameter int RST_DELAY   = 8,
    parameter int WIN_MIN     = 10,
    parameter int WIN_MAX     = 30,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_ok,
    input  logic shutdown,
    input  logic wd_en,
    input  logic kick,
    output logic sys_rst_n,
    output logic wd_out_n
);
    logic hold;
    logic rst_done;
    logic kick_fall;
    logic fault_on;
    logic pulse_end;

    assign hold = !sense_ok || shutdown;

    // Reset release timer.
    hold_timer #(.DELAY(RST_DELAY), .LOOKAHEAD(1'b0)) u_rst_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (hold),
        .expire (rst_done)
    );

    assign sys_rst_n = rst_done && !hold;

    // Kick synchronizer and edge detector.
    kick_edge_sync #(.STAGES(SYNC_STAGES)) u_kick (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick_async (kick),
        .fall       (kick_fall)
    );

    // Window state machine.
    window_judge #(.WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX)) u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (wd_en && !shutdown),
        .fall      (kick_fall),
        .pulse_end (pulse_end),
        .fault_on  (fault_on)
    );

    // Fault pulse stretcher, same delay as reset.
    hold_timer #(.DELAY(RST_DELAY), .LOOKAHEAD(1'b1)) u_pulse_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!fault_on),
        .expire (pulse_end)
    );

    assign wd_out_n = !(fault_on && !shutdown);
endmodule

// File: rtl/sup_checker.sv
// Checker: temporal properties of the supervisor outputs, built from
// independent run-length counters. Bound to the top below.
module sup_checker #(
    parameter int RST_DELAY = 8
) (
    input logic clk,
    input logic rst_n,
    input logic sense_ok,
    input logic shutdown,
    input logic wd_en,
    input logic sys_rst_n,
    input logic wd_out_n
);
    localparam int QW = sup_pkg::bits_for(RST_DELAY);
    localparam logic [QW-1:0] QMAX = QW'(RST_DELAY);

    logic [QW-1:0] quiet;
    logic [15:0]   lowrun;

    // Clean-cycle count since the last reset condition.
    always_ff @(posedge clk) begin
        if (!rst_n)                    quiet <= '0;
        else if (!sense_ok || shutdown) quiet <= '0;
        else if (quiet != QMAX)        quiet <= quiet + 1'b1;
    end

    // Length of the current low run on the watchdog output.
    always_ff @(posedge clk) begin
        if (!rst_n)                          lowrun <= '0;
        else if (wd_out_n)                   lowrun <= '0;
        else if (lowrun != 16'hFFFF)         lowrun <= lowrun + 1'b1;
    end

    p_rst_low_on_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_ok || shutdown) |-> !sys_rst_n);

    p_no_early_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_n |-> (quiet == QMAX));

    p_release_after_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet == QMAX && sense_ok && !shutdown) |-> sys_rst_n);

    p_wd_quiet_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown || $past(!wd_en)) |-> wd_out_n);

    p_pulse_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wd_out_n) && !shutdown && wd_en && $past(wd_en))
        |-> (lowrun == 16'(RST_DELAY)));

    p_fault_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_out_n) |-> $past(wd_en));
endmodule

bind window_watchdog_sup sup_checker #(.RST_DELAY(RST_DELAY)) u_sup_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sense_ok  (sense_ok),
    .shutdown  (shutdown),
    .wd_en     (wd_en),
    .sys_rst_n (sys_rst_n),
    .wd_out_n  (wd_out_n)
);

// File: tb/window_watchdog_sup_bench.sv
// Bench: the driver schedules expected output values by cycle into a
// queue; the monitor pops and compares them one ns before each edge.
module window_watchdog_sup_bench;
    localparam int D    = 8;
    localparam int WMIN = 10;
    localparam int WMAX = 30;

    logic clk = 1'b0;
    logic rst_n, sense_ok, shutdown, wd_en, kick;
    logic sys_rst_n, wd_out_n;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        string req;
        bit    sel_wd;
        bit    val;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    window_watchdog_sup #(.RST_DELAY(D), .WIN_MIN(WMIN), .WIN_MAX(WMAX)) u_window_watchdog_sup (
        .clk(clk), .rst_n(rst_n), .sense_ok(sense_ok), .shutdown(shutdown),
        .wd_en(wd_en), .kick(kick), .sys_rst_n(sys_rst_n), .wd_out_n(wd_out_n)
    );

    // Schedule an expected value (pushed in increasing due order).
    task automatic expect_at(input int due, input string req, input bit sel_wd, input bit val);
        exp_t e;
        e.due = due; e.req = req; e.sel_wd = sel_wd; e.val = val;
        exp_q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Falling edge now; the next falling edge comes gap cycles later.
    task automatic kick_gap(input int gap);
        kick = 1'b0;
        step(3);
        kick = 1'b1;
        step(gap - 3);
    endtask

    // Monitor: compare due items just before the next edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
                exp_t e;
                logic act;
                e = exp_q.pop_front();
                act = e.sel_wd ? wd_out_n : sys_rst_n;
                n_cmp++;
                if (e.due != cyc || act !== e.val) begin
                    n_bad++;
                    $display("FAIL %s: %s at cycle %0d actual %b expected %b (due %0d)",
                             e.req, e.sel_wd ? "wd_out_n" : "sys_rst_n", cyc, act, e.val, e.due);
                end
            end
        end
    end

    // Driver.
    initial begin
        int c, t;
        rst_n = 1'b0; sense_ok = 1'b1; shutdown = 1'b0; wd_en = 1'b0; kick = 1'b1;
        step(2);
        expect_at(cyc, "R1", 1'b0, 1'b0);
        expect_at(cyc, "R4", 1'b1, 1'b1);
        rst_n = 1'b1;
        c = cyc;
        expect_at(c + D - 1, "R1", 1'b0, 1'b0);
        expect_at(c + D, "R1", 1'b0, 1'b1);
        step(D + 2);

        // Supply sense drop.
        sense_ok = 1'b0;
        expect_at(cyc, "R2", 1'b0, 1'b0);
        step(5);
        expect_at(cyc, "R2", 1'b0, 1'b0);
        sense_ok = 1'b1;
        c = cyc;
        expect_at(c + D - 1, "R3", 1'b0, 1'b0);
        expect_at(c + D, "R3", 1'b0, 1'b1);
        step(D + 2);

        // Shutdown.
        shutdown = 1'b1;
        expect_at(cyc, "R2", 1'b0, 1'b0);
        expect_at(cyc, "R4", 1'b1, 1'b1);
        step(4);
        shutdown = 1'b0;
        c = cyc;
        expect_at(c + D - 1, "R3", 1'b0, 1'b0);
        expect_at(c + D, "R3", 1'b0, 1'b1);
        step(D + 2);

        // Disabled watchdog ignores fast kicks.
        for (int i = 0; i < 5; i++) begin
            expect_at(cyc, "R4", 1'b1, 1'b1);
            kick_gap(4);
        end
        expect_at(cyc + 3, "R4", 1'b1, 1'b1);
        step(6);

        // Enable, then legal intervals including both bounds.
        wd_en = 1'b1;
        step(2);
        expect_at(cyc, "R9", 1'b1, 1'b1);
        kick_gap(15);
        expect_at(cyc + 4, "R5", 1'b1, 1'b1);
        kick_gap(WMIN);
        expect_at(cyc + 4, "R5", 1'b1, 1'b1);
        kick_gap(WMAX);
        expect_at(cyc + 4, "R5", 1'b1, 1'b1);
        kick_gap(WMIN - 1);

        // Early edge, plus a kick during the pulse.
        t = cyc;
        expect_at(t + 2, "R6", 1'b1, 1'b1);
        expect_at(t + 3, "R6", 1'b1, 1'b0);
        expect_at(t + 3 + D - 1, "R8", 1'b1, 1'b0);
        expect_at(t + 3 + D, "R8", 1'b1, 1'b1);
        kick_gap(5);
        c = cyc;
        expect_at(c + 3 + WMAX + 1, "R10", 1'b1, 1'b1);
        expect_at(t + 3 + D + WMAX + 5, "R9", 1'b1, 1'b1);
        kick_gap(4);
        step(D + WMAX + 10);

        // Late fault without a second edge.
        t = cyc;
        expect_at(t + 3 + WMAX - 1, "R7", 1'b1, 1'b1);
        expect_at(t + 3 + WMAX, "R7", 1'b1, 1'b0);
        kick_gap(4);
        step(WMAX + 1);

        // Shutdown in the middle of the pulse.
        expect_at(cyc, "R7", 1'b1, 1'b0);
        step(1);
        shutdown = 1'b1;
        expect_at(cyc, "R8", 1'b1, 1'b1);
        expect_at(cyc, "R2", 1'b0, 1'b0);
        step(3);
        shutdown = 1'b0;
        c = cyc;
        expect_at(c, "R8", 1'b1, 1'b1);
        expect_at(c + D - 1, "R3", 1'b0, 1'b0);
        expect_at(c + D, "R3", 1'b0, 1'b1);
        step(D + 4);

        while (exp_q.size() > 0) step(1);
        step(1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog against a hung run.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual timeout, expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule